// File: doc/BRIEF.md
# SDIO Function-1 Access Decoder

This block sits behind the command and data framing of an SDIO card slave. For each single-byte (CMD52) or extended (CMD53) access, it decides whether the target in function 1 is a shared 8-bit register, the data FIFO window, or nothing. It then steers each data byte that crosses the bus. The framing logic in front of it supplies an already decoded command and one strobe per data byte. The storage behind it, which is a register file and the FIFO/DMA engine, receives select strobes and a qualified byte stream.

In the FIFO window, the number of bytes the DMA really moves does not come from the command's count. It comes from the start address: the distance from that address to the end of the window. The command's count only sets how many bytes cross the bus. Any bus byte past the address-derived length is dropped on a write and answered with zero on a read. The decoder counts the bytes itself, so the framing logic only has to deliver them.

Top module: `fn1_access_decoder`

## Requirements
- R1: An access whose function number is not 1 produces no FIFO or register strobe for any of its bytes. Each of its read bytes returns 0.
- R2: An access is a FIFO access when its start address lies in 0x090..0x1F7FF and is not a shared register, and the access is either CMD52 or CMD53 with the incrementing op bit at 1. A CMD53 with that bit at 0 in the window is unmapped. 0x090 counts as FIFO and 0x08F does not.
- R3: The requested length of a FIFO access is 0x1F800 minus its start address. For CMD52 it is 1.
- R4: The transfer length is 1 for CMD52. In CMD53 byte mode it is the 9-bit count. In CMD53 block mode it is the count times `blk_size`. A count of 0 stands for 512 in both modes.
- R5: On a FIFO write, byte k (counted from 0) gives `fifo_valid`=1, `fifo_dir`=1 and `fifo_wdata` equal to the bus byte when k is below the requested length. Otherwise the byte is dropped with no strobe.
- R6: On a FIFO read, byte k gives `fifo_valid`=1 with `fifo_dir`=0 and returns `fifo_rdata` when k is below the requested length. Otherwise it gives no strobe and returns 0.
- R7: The 52 shared registers map to `reg_idx` 0..51 in address order: 0x06C-0x077 to 0-11, 0x07A-0x07B to 12-13, 0x07E-0x07F to 14-15, 0x088-0x08B to 16-19, 0x09C-0x0BB to 20-51. A start address on a shared register takes priority over the FIFO window.
- R8: A register-class CMD53 steps the byte address by one per byte when the op bit is 1, and holds it when the op bit is 0. A byte whose address is not a shared register gives no strobe and reads 0. Register reads return `reg_rdata`.
- R9: An access starting at an address that is neither a shared register nor a FIFO-window location produces no strobes, and its read bytes return 0.
- R10: FIFO and register strobes appear in the cycle after the bus byte is taken. `host_rvalid` and `host_rdata` appear two cycles after it.
- R11: `busy` goes high on `cmd_valid` and low after the transfer-length-th byte. Bus bytes taken while not busy, or in the same cycle as `cmd_valid`, are ignored. A new `cmd_valid` restarts the decoder.
- R12: Synchronous reset clears `busy`, all strobes and `host_rvalid`. Bytes that follow a reset taken mid-transfer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle pulse: new decoded command |
| cmd_is_ext | input | 1 | 0 = single-byte command, 1 = extended command |
| cmd_fn | input | 3 | Function number |
| cmd_write | input | 1 | 1 = host writes, 0 = host reads |
| cmd_incr | input | 1 | Extended command op bit (1 = incrementing address) |
| cmd_block | input | 1 | Extended command block mode |
| cmd_addr | input | 17 | Start address |
| cmd_count | input | 9 | Byte or block count (0 = 512) |
| blk_size | input | 12 | Block size in bytes for block mode |
| bus_valid | input | 1 | One data byte crosses the bus this cycle |
| bus_wdata | input | 8 | Write data byte from host |
| host_rvalid | output | 1 | Read byte for host is valid |
| host_rdata | output | 8 | Read byte for host |
| busy | output | 1 | An access is in progress |
| fifo_valid | output | 1 | FIFO byte strobe (within requested length) |
| fifo_dir | output | 1 | 1 = byte into FIFO, 0 = byte pulled from FIFO |
| fifo_wdata | output | 8 | Byte into FIFO |
| fifo_rdata | input | 8 | Byte from FIFO, valid while the read strobe is high |
| reg_wr | output | 1 | Shared register write strobe |
| reg_rd | output | 1 | Shared register read strobe |
| reg_idx | output | 6 | Compact shared register index |
| reg_wdata | output | 8 | Shared register write data |
| reg_rdata | input | 8 | Shared register read data, valid while `reg_rd` is high |

## Verification
The decoder is exercised with FIFO accesses whose transfer length is shorter than, equal to and longer than the address-derived length. These are counted separately as strobed bytes, dropped writes and zero-filled reads, which separates a decoder that trusts the command count from one that trusts the address. Byte mode, block mode and a zero count each give a different transfer length. Function-number, op-bit and window-edge cases (0x08F against 0x090) check the classification. Register-class walks that cross the gaps in the register map check address stepping and compact indexing. Directed cases check the one- and two-cycle latencies and a reset taken mid-transfer.

// File: rtl/fn1_dec_pkg.sv
package fn1_dec_pkg;

  localparam int REG_IDX_W = 6;
  localparam int SPAN_AW   = 17;
  localparam int N_SPAN    = 5;

  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_SHREG = 2'd1,
    RGN_FIFO  = 2'd2
  } rgn_e;

  typedef struct packed {
    logic [SPAN_AW-1:0]   lo;
    logic [SPAN_AW-1:0]   hi;
    logic [REG_IDX_W-1:0] first;
  } span_t;

  // address spans of the shared byte registers, in ascending address order
  localparam span_t SPANS [N_SPAN] = '{
    '{17'h0006C, 17'h00077, 6'd0},
    '{17'h0007A, 17'h0007B, 6'd12},
    '{17'h0007E, 17'h0007F, 6'd14},
    '{17'h00088, 17'h0008B, 6'd16},
    '{17'h0009C, 17'h000BB, 6'd20}
  };

endpackage

// File: rtl/fn1_shreg_map.sv
module fn1_shreg_map
  import fn1_dec_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 hit,
  output logic [REG_IDX_W-1:0] idx
);

  logic [N_SPAN-1:0]    in_span;
  logic [REG_IDX_W-1:0] span_idx [N_SPAN];

  for (genvar k = 0; k < N_SPAN; k++) begin : g_span
    assign in_span[k]  = (addr >= ADDR_W'(SPANS[k].lo)) && (addr <= ADDR_W'(SPANS[k].hi));
    assign span_idx[k] = SPANS[k].first + REG_IDX_W'(addr - ADDR_W'(SPANS[k].lo));
  end

  always_comb begin
    hit = |in_span;
    idx = '0;
    for (int k = 0; k < N_SPAN; k++) begin
      if (in_span[k]) idx = span_idx[k];
    end
  end

endmodule

// File: rtl/fn1_cmd_classify.sv
module fn1_cmd_classify
  import fn1_dec_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int FN_W    = 3,
  parameter int COUNT_W = 9,
  parameter int BLKSZ_W = 12,
  parameter int FN_ID   = 1,
  parameter int WIN_LO  = 'h00090,
  parameter int WIN_END = 'h1F800,
  localparam int RLEN_W = ADDR_W + 1,
  localparam int XLEN_W = COUNT_W + 1 + BLKSZ_W
) (
  input  logic               is_ext,
  input  logic [FN_W-1:0]    fn,
  input  logic               incr,
  input  logic               block,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [COUNT_W-1:0] count,
  input  logic [BLKSZ_W-1:0] blk_size,
  output rgn_e               rgn,
  output logic [RLEN_W-1:0]  req_len,
  output logic [XLEN_W-1:0]  xfer_len
);

  localparam int CNT_E_W = COUNT_W + 1;

  logic                 sh_hit;
  logic [REG_IDX_W-1:0] sh_idx_unused;
  logic                 fn_ok;
  logic                 in_win;
  logic [CNT_E_W-1:0]   cnt_eff;

  fn1_shreg_map #(.ADDR_W(ADDR_W)) start_map_i (
    .addr (addr),
    .hit  (sh_hit),
    .idx  (sh_idx_unused)
  );

  assign fn_ok  = (fn == FN_W'(FN_ID));
  assign in_win = ({1'b0, addr} >= RLEN_W'(WIN_LO)) && ({1'b0, addr} < RLEN_W'(WIN_END));

  always_comb begin
    if (!fn_ok)                      rgn = RGN_NONE;
    else if (sh_hit)                 rgn = RGN_SHREG;
    else if (in_win && (!is_ext || incr)) rgn = RGN_FIFO;
    else                             rgn = RGN_NONE;
  end

  assign req_len = is_ext ? (RLEN_W'(WIN_END) - {1'b0, addr}) : RLEN_W'(1);

  assign cnt_eff = (count == '0) ? (CNT_E_W'(1) << COUNT_W) : {1'b0, count};

  always_comb begin
    if (!is_ext)    xfer_len = XLEN_W'(1);
    else if (block) xfer_len = XLEN_W'(cnt_eff) * XLEN_W'(blk_size);
    else            xfer_len = XLEN_W'(cnt_eff);
  end

  // start-address index is only needed per byte, in the sequencer
  logic unused_ok;
  assign unused_ok = ^sh_idx_unused;

endmodule

// File: rtl/fn1_byte_seq.sv
module fn1_byte_seq
  import fn1_dec_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int DATA_W  = 8,
  parameter int RLEN_W  = 18,
  parameter int XLEN_W  = 22,
  localparam int CMP_W  = (XLEN_W > RLEN_W) ? XLEN_W : RLEN_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic                 cmd_write,
  input  logic                 cmd_is_ext,
  input  logic                 cmd_incr,
  input  rgn_e                 cmd_rgn,
  input  logic [RLEN_W-1:0]    cmd_req_len,
  input  logic [XLEN_W-1:0]    cmd_xfer_len,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic                 bus_valid,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic                 busy,
  output logic                 fifo_valid,
  output logic                 fifo_dir,
  output logic [DATA_W-1:0]    fifo_wdata,
  output logic                 reg_wr,
  output logic                 reg_rd,
  output logic [REG_IDX_W-1:0] reg_idx,
  output logic [DATA_W-1:0]    reg_wdata,
  output logic                 rd_pend,
  output rgn_e                 rd_src
);

  logic [XLEN_W-1:0]    idx_q;
  logic [ADDR_W-1:0]    addr_q;
  rgn_e                 rgn_q;
  logic [RLEN_W-1:0]    req_q;
  logic [XLEN_W-1:0]    xfer_q;
  logic                 wr_q;
  logic                 step_q;

  logic                 sh_hit;
  logic [REG_IDX_W-1:0] sh_idx;
  logic                 take;
  logic                 in_req;
  logic                 take_fifo;
  logic                 take_reg;

  fn1_shreg_map #(.ADDR_W(ADDR_W)) byte_map_i (
    .addr (addr_q),
    .hit  (sh_hit),
    .idx  (sh_idx)
  );

  assign take      = bus_valid && busy && !cmd_valid;
  assign in_req    = CMP_W'(idx_q) < CMP_W'(req_q);
  assign take_fifo = (rgn_q == RGN_FIFO) && in_req;
  assign take_reg  = (rgn_q == RGN_SHREG) && sh_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      idx_q      <= '0;
      addr_q     <= '0;
      rgn_q      <= RGN_NONE;
      req_q      <= '0;
      xfer_q     <= '0;
      wr_q       <= 1'b0;
      step_q     <= 1'b0;
      fifo_valid <= 1'b0;
      fifo_dir   <= 1'b0;
      fifo_wdata <= '0;
      reg_wr     <= 1'b0;
      reg_rd     <= 1'b0;
      reg_idx    <= '0;
      reg_wdata  <= '0;
      rd_pend    <= 1'b0;
      rd_src     <= RGN_NONE;
    end else begin
      fifo_valid <= 1'b0;
      reg_wr     <= 1'b0;
      reg_rd     <= 1'b0;
      rd_pend    <= 1'b0;
      rd_src     <= RGN_NONE;
      if (cmd_valid) begin
        busy   <= 1'b1;
        idx_q  <= '0;
        addr_q <= cmd_addr;
        rgn_q  <= cmd_rgn;
        req_q  <= cmd_req_len;
        xfer_q <= cmd_xfer_len;
        wr_q   <= cmd_write;
        step_q <= cmd_is_ext && cmd_incr;
      end else if (take) begin
        fifo_valid <= take_fifo;
        fifo_dir   <= wr_q;
        fifo_wdata <= bus_wdata;
        reg_wr     <= take_reg && wr_q;
        reg_rd     <= take_reg && !wr_q;
        reg_idx    <= sh_idx;
        reg_wdata  <= bus_wdata;
        rd_pend    <= !wr_q;
        if (!wr_q) begin
          if (take_fifo)     rd_src <= RGN_FIFO;
          else if (take_reg) rd_src <= RGN_SHREG;
        end
        idx_q <= idx_q + XLEN_W'(1);
        if (step_q) addr_q <= addr_q + ADDR_W'(1);
        if (idx_q + XLEN_W'(1) == xfer_q) busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/fn1_read_ret.sv
module fn1_read_ret
  import fn1_dec_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_pend,
  input  rgn_e              rd_src,
  input  logic [DATA_W-1:0] fifo_rdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              host_rvalid,
  output logic [DATA_W-1:0] host_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rd_pend;
      unique case (rd_src)
        RGN_FIFO:  host_rdata <= fifo_rdata;
        RGN_SHREG: host_rdata <= reg_rdata;
        default:   host_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/fn1_access_decoder.sv
module fn1_access_decoder
  import fn1_dec_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int FN_W    = 3,
  parameter int COUNT_W = 9,
  parameter int BLKSZ_W = 12,
  parameter int DATA_W  = 8,
  parameter int FN_ID   = 1,
  parameter int WIN_LO  = 'h00090,
  parameter int WIN_END = 'h1F800
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic                 cmd_is_ext,
  input  logic [FN_W-1:0]      cmd_fn,
  input  logic                 cmd_write,
  input  logic                 cmd_incr,
  input  logic                 cmd_block,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [COUNT_W-1:0]   cmd_count,
  input  logic [BLKSZ_W-1:0]   blk_size,
  input  logic                 bus_valid,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic                 host_rvalid,
  output logic [DATA_W-1:0]    host_rdata,
  output logic                 busy,
  output logic                 fifo_valid,
  output logic                 fifo_dir,
  output logic [DATA_W-1:0]    fifo_wdata,
  input  logic [DATA_W-1:0]    fifo_rdata,
  output logic                 reg_wr,
  output logic                 reg_rd,
  output logic [REG_IDX_W-1:0] reg_idx,
  output logic [DATA_W-1:0]    reg_wdata,
  input  logic [DATA_W-1:0]    reg_rdata
);

  localparam int RLEN_W = ADDR_W + 1;
  localparam int XLEN_W = COUNT_W + 1 + BLKSZ_W;

  rgn_e              c_rgn;
  logic [RLEN_W-1:0] c_req;
  logic [XLEN_W-1:0] c_xfer;
  logic              rd_pend;
  rgn_e              rd_src;

  fn1_cmd_classify #(
    .ADDR_W (ADDR_W), .FN_W (FN_W), .COUNT_W (COUNT_W), .BLKSZ_W (BLKSZ_W),
    .FN_ID (FN_ID), .WIN_LO (WIN_LO), .WIN_END (WIN_END)
  ) classify_i (
    .is_ext   (cmd_is_ext),
    .fn       (cmd_fn),
    .incr     (cmd_incr),
    .block    (cmd_block),
    .addr     (cmd_addr),
    .count    (cmd_count),
    .blk_size (blk_size),
    .rgn      (c_rgn),
    .req_len  (c_req),
    .xfer_len (c_xfer)
  );

  fn1_byte_seq #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .RLEN_W (RLEN_W), .XLEN_W (XLEN_W)
  ) seq_i (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_write    (cmd_write),
    .cmd_is_ext   (cmd_is_ext),
    .cmd_incr     (cmd_incr),
    .cmd_rgn      (c_rgn),
    .cmd_req_len  (c_req),
    .cmd_xfer_len (c_xfer),
    .cmd_addr     (cmd_addr),
    .bus_valid    (bus_valid),
    .bus_wdata    (bus_wdata),
    .busy         (busy),
    .fifo_valid   (fifo_valid),
    .fifo_dir     (fifo_dir),
    .fifo_wdata   (fifo_wdata),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_idx      (reg_idx),
    .reg_wdata    (reg_wdata),
    .rd_pend      (rd_pend),
    .rd_src       (rd_src)
  );

  fn1_read_ret #(.DATA_W (DATA_W)) ret_i (
    .clk         (clk),
    .rst         (rst),
    .rd_pend     (rd_pend),
    .rd_src      (rd_src),
    .fifo_rdata  (fifo_rdata),
    .reg_rdata   (reg_rdata),
    .host_rvalid (host_rvalid),
    .host_rdata  (host_rdata)
  );

endmodule

// File: rtl/fn1_access_decoder_chk.sv
module fn1_access_decoder_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              bus_valid,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              busy,
  input logic              fifo_valid,
  input logic              fifo_dir,
  input logic [DATA_W-1:0] fifo_wdata,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic              host_rvalid,
  input logic [DATA_W-1:0] host_rdata
);

  // R5
  fifo_wdata_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_valid && fifo_dir) |-> ($past(bus_valid) && fifo_wdata == $past(bus_wdata)));

  // R10
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> $past(bus_valid, 2));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cmd_valid) |=> !(fifo_valid || reg_wr || reg_rd));

  // R6
  zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rvalid && !$past(fifo_valid) && !$past(reg_rd)) |-> host_rdata == '0);

  // R8
  one_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fifo_valid, reg_wr, reg_rd}));

  // R12
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!busy && !fifo_valid && !host_rvalid && !reg_wr && !reg_rd));

endmodule

bind fn1_access_decoder fn1_access_decoder_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .cmd_valid   (cmd_valid),
  .bus_valid   (bus_valid),
  .bus_wdata   (bus_wdata),
  .busy        (busy),
  .fifo_valid  (fifo_valid),
  .fifo_dir    (fifo_dir),
  .fifo_wdata  (fifo_wdata),
  .reg_wr      (reg_wr),
  .reg_rd      (reg_rd),
  .host_rvalid (host_rvalid),
  .host_rdata  (host_rdata)
);

// File: tb/fn1_access_decoder_tb.sv
module fn1_access_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_is_ext = 1'b0, cmd_write = 1'b0;
  logic        cmd_incr = 1'b0, cmd_block = 1'b0;
  logic [2:0]  cmd_fn = 3'd1;
  logic [16:0] cmd_addr = '0;
  logic [8:0]  cmd_count = '0;
  logic [11:0] blk_size = 12'd64;
  logic        bus_valid = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        host_rvalid, busy, fifo_valid, fifo_dir, reg_wr, reg_rd;
  logic [7:0]  host_rdata, fifo_wdata, reg_wdata, fifo_rdata, reg_rdata;
  logic [5:0]  reg_idx;

  always #2.5 clk = ~clk;

  assign fifo_rdata = 8'h5A;
  assign reg_rdata  = {2'b10, reg_idx};

  fn1_access_decoder dut_i (
    .clk, .rst, .cmd_valid, .cmd_is_ext, .cmd_fn, .cmd_write, .cmd_incr,
    .cmd_block, .cmd_addr, .cmd_count, .blk_size, .bus_valid, .bus_wdata,
    .host_rvalid, .host_rdata, .busy, .fifo_valid, .fifo_dir, .fifo_wdata,
    .fifo_rdata, .reg_wr, .reg_rd, .reg_idx, .reg_wdata, .reg_rdata
  );

  int n_chk = 0, n_bad = 0;
  int n_fifo = 0, n_reg = 0, n_zero = 0;

  always @(negedge clk) if (!rst) begin
    if (fifo_valid) n_fifo++;
    if (reg_wr || reg_rd) n_reg++;
    if (host_rvalid && host_rdata == 8'h00) n_zero++;
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  typedef struct packed {
    logic        wr;
    logic        ext;
    logic [2:0]  fn;
    logic        incr;
    logic        blk;
    logic [16:0] addr;
    logic [8:0]  cnt;
    logic [10:0] nb;
    logic [10:0] e_fifo;
    logic [10:0] e_reg;
    logic [10:0] e_zero;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,3'd1,1'b1,1'b0,17'h1F7FC,9'd8,  11'd8,  11'd4,  11'd0,11'd0},
    '{1'b0,1'b1,3'd1,1'b1,1'b0,17'h1F7FC,9'd8,  11'd8,  11'd4,  11'd0,11'd4},
    '{1'b0,1'b1,3'd1,1'b1,1'b0,17'h1F7F0,9'd10, 11'd10, 11'd10, 11'd0,11'd0},
    '{1'b0,1'b0,3'd1,1'b0,1'b0,17'h1F000,9'd0,  11'd1,  11'd1,  11'd0,11'd0},
    '{1'b0,1'b0,3'd2,1'b0,1'b0,17'h1F000,9'd0,  11'd1,  11'd0,  11'd0,11'd1},
    '{1'b0,1'b1,3'd1,1'b0,1'b0,17'h1F700,9'd4,  11'd4,  11'd0,  11'd0,11'd4},
    '{1'b1,1'b1,3'd1,1'b1,1'b1,17'h1F79C,9'd2,  11'd130,11'd100,11'd0,11'd0},
    '{1'b0,1'b1,3'd1,1'b1,1'b0,17'h1F5A8,9'd0,  11'd512,11'd512,11'd0,11'd0},
    '{1'b1,1'b1,3'd1,1'b1,1'b0,17'h00076,9'd6,  11'd6,  11'd0,  11'd4,11'd0},
    '{1'b0,1'b1,3'd1,1'b0,1'b0,17'h000BB,9'd3,  11'd3,  11'd0,  11'd3,11'd0},
    '{1'b1,1'b0,3'd1,1'b0,1'b0,17'h0008D,9'd0,  11'd1,  11'd0,  11'd0,11'd0},
    '{1'b0,1'b0,3'd1,1'b0,1'b0,17'h00044,9'd0,  11'd1,  11'd0,  11'd0,11'd1},
    '{1'b0,1'b1,3'd1,1'b1,1'b0,17'h000BA,9'd4,  11'd4,  11'd0,  11'd2,11'd2},
    '{1'b1,1'b1,3'd1,1'b1,1'b0,17'h00090,9'd3,  11'd3,  11'd3,  11'd0,11'd0},
    '{1'b0,1'b1,3'd1,1'b1,1'b0,17'h0008F,9'd1,  11'd1,  11'd0,  11'd0,11'd1}
  };
  localparam string VTAG [NV] = '{
    "R3 R5", "R3 R6", "R3 R6", "R3 R2", "R1", "R2", "R4 R11", "R4",
    "R8", "R8", "R9", "R9", "R7 R8", "R2", "R2"
  };

  task automatic send_cmd(vec_t v);
    cmd_write = v.wr; cmd_is_ext = v.ext; cmd_fn = v.fn; cmd_incr = v.incr;
    cmd_block = v.blk; cmd_addr = v.addr; cmd_count = v.cnt;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_vec(vec_t v, string tag);
    int f0 = n_fifo, r0 = n_reg, z0 = n_zero;
    send_cmd(v);
    for (int i = 0; i < int'(v.nb); i++) begin
      bus_valid = 1'b1; bus_wdata = 8'(i + 1);
      @(negedge clk);
    end
    bus_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk({tag, " fifo strobes"}, n_fifo - f0, int'(v.e_fifo));
    chk({tag, " reg strobes"},  n_reg - r0,  int'(v.e_reg));
    chk({tag, " zero reads"},   n_zero - z0, int'(v.e_zero));
    chk({tag, " R11 busy end"}, int'(busy), 0);
  endtask

  task automatic reg_map(logic [16:0] a, int exp);
    send_cmd('{1'b0,1'b0,3'd1,1'b0,1'b0,a,9'd0,11'd1,11'd0,11'd0,11'd0});
    bus_valid = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0;
    chk("R7 reg_rd", int'(reg_rd), 1);
    chk("R7 reg_idx", int'(reg_idx), exp);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busy", int'(busy), 0);
    chk("R12 fifo_valid", int'(fifo_valid), 0);
    chk("R12 host_rvalid", int'(host_rvalid), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int k = 0; k < NV; k++) run_vec(VECS[k], VTAG[k]);

    // R10 R5 write strobe one cycle after the byte
    send_cmd('{1'b1,1'b0,3'd1,1'b0,1'b0,17'h1F000,9'd0,11'd1,11'd0,11'd0,11'd0});
    chk("R11 busy after cmd", int'(busy), 1);
    bus_valid = 1'b1; bus_wdata = 8'h3C;
    @(negedge clk);
    bus_valid = 1'b0;
    chk("R10 fifo_valid", int'(fifo_valid), 1);
    chk("R5 fifo_dir", int'(fifo_dir), 1);
    chk("R5 fifo_wdata", int'(fifo_wdata), 8'h3C);
    @(negedge clk);
    chk("R10 strobe single", int'(fifo_valid), 0);
    repeat (2) @(negedge clk);

    // R10 R6 read return two cycles after the byte
    send_cmd('{1'b0,1'b0,3'd1,1'b0,1'b0,17'h1F000,9'd0,11'd1,11'd0,11'd0,11'd0});
    bus_valid = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0;
    chk("R6 fifo_dir read", int'(fifo_dir), 0);
    chk("R10 rvalid not yet", int'(host_rvalid), 0);
    @(negedge clk);
    chk("R10 rvalid", int'(host_rvalid), 1);
    chk("R6 rdata", int'(host_rdata), 8'h5A);
    repeat (2) @(negedge clk);

    // R7 compact index at span edges
    reg_map(17'h0006C, 0);
    reg_map(17'h0007A, 12);
    reg_map(17'h00088, 16);
    reg_map(17'h0009C, 20);
    reg_map(17'h000BB, 51);

    // R12 reset mid-transfer, later bytes ignored
    begin
      int f0;
      send_cmd('{1'b1,1'b1,3'd1,1'b1,1'b0,17'h1F000,9'd8,11'd0,11'd0,11'd0,11'd0});
      bus_valid = 1'b1;
      repeat (2) @(negedge clk);
      bus_valid = 1'b0;
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R12 busy cleared", int'(busy), 0);
      f0 = n_fifo;
      bus_valid = 1'b1;
      repeat (3) @(negedge clk);
      bus_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk("R12 bytes ignored", n_fifo - f0, 0);
    end

    // R11 restart: new command mid-transfer uses new parameters
    begin
      int f0;
      send_cmd('{1'b1,1'b1,3'd1,1'b1,1'b0,17'h1F000,9'd8,11'd0,11'd0,11'd0,11'd0});
      bus_valid = 1'b1;
      @(negedge clk);
      bus_valid = 1'b0;
      @(negedge clk);
      f0 = n_fifo;
      send_cmd('{1'b1,1'b1,3'd1,1'b1,1'b0,17'h1F7FE,9'd4,11'd0,11'd0,11'd0,11'd0});
      bus_valid = 1'b1;
      repeat (4) @(negedge clk);
      bus_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11 restart fifo strobes", n_fifo - f0, 2);
      chk("R11 restart busy", int'(busy), 0);
    end

    finish_run();
  end

endmodule